// File: doc/BRIEF.md
# Maskable and Non-Maskable Interrupt Acceptance Unit

This unit sits beside the instruction sequencer of an 8-bit core with a 16-bit address space. At every retired instruction it decides whether a pending interrupt is taken, and if one is, where execution continues. It holds the two interrupt-enable flip-flops (`iff1`, `iff2`) and the one-instruction shadow that follows an enable instruction. It also holds the mode register, which selects among three dispatch styles:
- mode 0 decodes an opcode byte that comes from the acknowledge cycle;
- mode 1 jumps to a fixed restart address;
- mode 2 fetches the new program counter from a table.

The sequencer strobes `retire` once per instruction and marks enable (`retire_ei`) and disable (`retire_di`) instructions. The acknowledge value `ack_vec` must be valid in the same cycle as `retire`. An accepted interrupt shows up as one-cycle pulses on the output side:
- `accept` marks every acceptance;
- `push_pc` asks the sequencer to push the current PC;
- `pc_load` loads `new_pc`;
- `leave_halt` releases a halted core.

`ei_done` tells an external controller that an enable has taken effect.

The mode-2 table read is a valid/ready request. `tbl_rd_valid` stays high, and `tbl_rd_addr` stays stable, until the cycle in which `tbl_rd_ready` is high. After that the unit waits for exactly one `tbl_rsp_valid` beat carrying the 16-bit table word; it has no ready signal of its own for that beat. While a table read is in flight the unit is busy, and any instruction retired during that time is ignored.

Top module: `irq_accept_unit`

## Requirements
- R1: A latched NMI (set by a rising edge of `nmi_req`) wins over a pending maskable request. Taking it clears `iff1`, leaves `iff2` unchanged, pulses `push_pc` and `pc_load`, loads `new_pc`=0x0066, pulses `nmi_taken`, and leaves `wz` unchanged.
- R2: A maskable request (latched by a one-cycle `int_req` pulse) is taken only when `iff1` is set after the retiring instruction. Taking it clears `iff1`, `iff2` and the request latch.
- R3: In mode 1 (`im_val`=1), a taken request pulses `push_pc` and `pc_load` with `new_pc`=0x0038.
- R4: In mode 0 (`im_val`=0), the opcode byte `ack_vec[7:0]` is decoded as follows, with the target taken from `ack_vec[23:8]`:
  - 0x00 and unlisted codes: no push and no load;
  - 0xC3: load the target without a push;
  - 0xCD: push, then load the target;
  - a restart code 11nnn111: push, then load nnn*8.
- R5: In mode 2 (`im_val`=2 or 3), a taken request pulses `push_pc` and then raises `tbl_rd_valid` with `tbl_rd_addr`={`i_reg`,`ack_vec[7:0]`}. Valid and address hold until ready is seen. The next `tbl_rsp_valid` beat pulses `pc_load` with `new_pc` equal to `tbl_rsp_data`.
- R6: A retiring enable instruction sets `iff1` and `iff2` and makes no interrupt check on its own boundary. Checking resumes at the next retire.
- R7: `ei_done` pulses only when the previous retire was an enable and the current one is neither an enable nor a disable.
- R8: A retiring disable instruction clears `iff1` and `iff2`, and the check on that same boundary already sees them cleared.
- R9: While `iff1` is clear, a check replaces the maskable latch with (latch AND `int_pend`), so an unmasked request that is dropped is lost.
- R10: After reset:
  - the mode is 0;
  - `iff1`, `iff2`, the enable shadow and all pulses are 0;
  - `wz` and `new_pc` are 0;
  - no table read is pending.
- R11: Every acceptance pulses `leave_halt` together with `accept`.
- R12: `wz` takes the new PC whenever a maskable acceptance loads the PC, in any mode.
- R13: `retire` strobes that arrive while a mode-2 table read is in flight change no state and cause no acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire | input | 1 | One instruction retires this cycle |
| retire_ei | input | 1 | Retiring instruction is an interrupt enable |
| retire_di | input | 1 | Retiring instruction is an interrupt disable |
| im_wr | input | 1 | Write the mode register |
| im_val | input | 2 | Mode value (0, 1, 2; 3 acts as 2) |
| nmi_req | input | 1 | Non-maskable request, edge sensitive |
| int_req | input | 1 | Maskable request strobe |
| int_pend | input | 1 | Keep-mask applied to the maskable latch while disabled |
| i_reg | input | 8 | Table base (upper address byte) |
| ack_vec | input | 24 | Acknowledge value: [7:0] opcode/index, [23:8] target |
| tbl_rd_ready | input | 1 | Table read request accepted |
| tbl_rsp_valid | input | 1 | Table read data valid |
| tbl_rsp_data | input | 16 | Table read data |
| accept | output | 1 | Interrupt accepted (pulse) |
| nmi_taken | output | 1 | Accepted interrupt was the NMI (pulse) |
| push_pc | output | 1 | Push current PC (pulse) |
| pc_load | output | 1 | Load `new_pc` (pulse) |
| new_pc | output | 16 | Next program counter |
| leave_halt | output | 1 | Release halt (pulse) |
| ei_done | output | 1 | Enable took effect (pulse) |
| iff1 | output | 1 | Interrupt enable flip-flop 1 |
| iff2 | output | 1 | Interrupt enable flip-flop 2 |
| tbl_rd_valid | output | 1 | Table read request valid |
| tbl_rd_addr | output | 16 | Table read address |
| wz | output | 16 | Internal jump-target register |

## Verification
The hardest situation to reach from the ports is a retire that lands while a mode-2 table read is stalled. To get there, the bench takes a mode-2 interrupt and holds `tbl_rd_ready` low for several cycles, then retires an enable instruction into the stall and confirms that `iff1` stays clear. A second hard case is an enable followed at once by a disable while a request is pending, which exercises the shadow and the disable-boundary check together. For that, the bench raises `int_req` before the pair and confirms that neither `accept` nor `ei_done` pulses, and that the latch survives to be taken later.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {IM_0 = 2'd0, IM_1 = 2'd1, IM_2 = 2'd2} im_mode_t;
  typedef enum logic [1:0] {SQ_IDLE = 2'd0, SQ_REQ = 2'd1, SQ_RSP = 2'd2} seq_state_t;
  typedef struct packed {
    logic push;
    logic load;
  } m0_act_t;
endpackage

// File: rtl/irq_m0_decode.sv
module irq_m0_decode
  import irq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [7:0]        op,
  input  logic [ADDR_W-1:0] tgt,
  output m0_act_t           act,
  output logic [ADDR_W-1:0] pc
);
  always_comb begin
    act = '0;
    pc  = '0;
    if (op == 8'hC3) begin
      act.load = 1'b1;
      pc       = tgt;
    end else if (op == 8'hCD) begin
      act.push = 1'b1;
      act.load = 1'b1;
      pc       = tgt;
    end else if (op[7:6] == 2'b11 && op[2:0] == 3'b111) begin
      act.push = 1'b1;
      act.load = 1'b1;
      pc[5:3]  = op[5:3];
    end
  end
endmodule

// File: rtl/irq_enable_ctl.sv
module irq_enable_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ret,
  input  logic ret_ei,
  input  logic ret_di,
  input  logic busy,
  input  logic take_nmi,
  input  logic take_int,
  output logic check,
  output logic iff1_eff,
  output logic iff1,
  output logic iff2,
  output logic ei_done
);
  logic ret_g;
  logic iff1_q, iff2_q, shadow_q, ei_done_q;

  assign ret_g    = ret & ~busy;
  assign check    = ret_g & ~ret_ei;
  assign iff1_eff = iff1_q & ~ret_di;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iff1_q    <= 1'b0;
      iff2_q    <= 1'b0;
      shadow_q  <= 1'b0;
      ei_done_q <= 1'b0;
    end else begin
      ei_done_q <= check & ~ret_di & shadow_q;
      if (ret_g) shadow_q <= ret_ei;
      if (ret_g && ret_ei) begin
        iff1_q <= 1'b1;
        iff2_q <= 1'b1;
      end else if (ret_g && ret_di) begin
        iff1_q <= 1'b0;
        iff2_q <= 1'b0;
      end
      if (take_int) begin
        iff1_q <= 1'b0;
        iff2_q <= 1'b0;
      end else if (take_nmi) begin
        iff1_q <= 1'b0;
      end
    end
  end

  assign iff1    = iff1_q;
  assign iff2    = iff2_q;
  assign ei_done = ei_done_q;

  assert_int_clears_both_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_int |=> (!iff1_q && !iff2_q));

  assert_nmi_keeps_iff2_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (take_nmi && !ret_di) |=> (!iff1_q && iff2_q == $past(iff2_q)));

  assert_ei_boundary_no_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && ret_ei) |-> (!take_int && !take_nmi));
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_pkg::*;
#(
  parameter int          ADDR_W = 16,
  parameter logic [15:0] NMI_PC = 16'h0066,
  parameter logic [15:0] M1_PC  = 16'h0038
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              check,
  input  logic              iff1_eff,
  input  logic              nmi_req,
  input  logic              int_req,
  input  logic              int_pend,
  input  logic              im_wr,
  input  logic [1:0]        im_val,
  input  logic [ADDR_W-9:0] i_reg,
  input  logic [ADDR_W+7:0] ack_vec,
  input  logic              tbl_rd_ready,
  input  logic              tbl_rsp_valid,
  input  logic [ADDR_W-1:0] tbl_rsp_data,
  output logic              take_nmi,
  output logic              take_int,
  output logic              busy,
  output logic              accept,
  output logic              nmi_taken,
  output logic              push_pc,
  output logic              pc_load,
  output logic [ADDR_W-1:0] new_pc,
  output logic              leave_halt,
  output logic              tbl_rd_valid,
  output logic [ADDR_W-1:0] tbl_rd_addr,
  output logic [ADDR_W-1:0] wz
);
  im_mode_t          mode_q;
  seq_state_t        state_q;
  logic              nmi_prev_q, nmi_lat_q, int_lat_q;
  logic              int_nxt;
  logic [ADDR_W-1:0] addr_q, pc_q, wz_q;
  logic              acc_q, nmi_q, push_q, load_q, halt_q;
  m0_act_t           m0_act;
  logic [ADDR_W-1:0] m0_pc;

  irq_m0_decode #(.ADDR_W(ADDR_W)) u_m0 (
    .op  (ack_vec[7:0]),
    .tgt (ack_vec[ADDR_W+7:8]),
    .act (m0_act),
    .pc  (m0_pc)
  );

  assign busy     = (state_q != SQ_IDLE);
  assign take_nmi = check & nmi_lat_q;
  assign take_int = check & ~nmi_lat_q & int_lat_q & iff1_eff;

  always_comb begin
    int_nxt = int_lat_q;
    if (take_int)                 int_nxt = 1'b0;
    else if (check && !iff1_eff)  int_nxt = int_lat_q & int_pend;
    int_nxt = int_nxt | int_req;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= IM_0;
      state_q    <= SQ_IDLE;
      nmi_prev_q <= 1'b0;
      nmi_lat_q  <= 1'b0;
      int_lat_q  <= 1'b0;
      addr_q     <= '0;
      pc_q       <= '0;
      wz_q       <= '0;
      acc_q      <= 1'b0;
      nmi_q      <= 1'b0;
      push_q     <= 1'b0;
      load_q     <= 1'b0;
      halt_q     <= 1'b0;
    end else begin
      acc_q      <= 1'b0;
      nmi_q      <= 1'b0;
      push_q     <= 1'b0;
      load_q     <= 1'b0;
      halt_q     <= 1'b0;
      nmi_prev_q <= nmi_req;
      nmi_lat_q  <= (nmi_lat_q & ~take_nmi) | (nmi_req & ~nmi_prev_q);
      int_lat_q  <= int_nxt;
      if (im_wr) begin
        case (im_val)
          2'd0:    mode_q <= IM_0;
          2'd1:    mode_q <= IM_1;
          default: mode_q <= IM_2;
        endcase
      end
      case (state_q)
        SQ_REQ: if (tbl_rd_ready) state_q <= SQ_RSP;
        SQ_RSP: if (tbl_rsp_valid) begin
          load_q  <= 1'b1;
          pc_q    <= tbl_rsp_data;
          wz_q    <= tbl_rsp_data;
          state_q <= SQ_IDLE;
        end
        default: ;
      endcase
      if (take_nmi) begin
        acc_q  <= 1'b1;
        nmi_q  <= 1'b1;
        push_q <= 1'b1;
        load_q <= 1'b1;
        halt_q <= 1'b1;
        pc_q   <= NMI_PC[ADDR_W-1:0];
      end else if (take_int) begin
        acc_q  <= 1'b1;
        halt_q <= 1'b1;
        case (mode_q)
          IM_0: begin
            push_q <= m0_act.push;
            load_q <= m0_act.load;
            if (m0_act.load) begin
              pc_q <= m0_pc;
              wz_q <= m0_pc;
            end
          end
          IM_1: begin
            push_q <= 1'b1;
            load_q <= 1'b1;
            pc_q   <= M1_PC[ADDR_W-1:0];
            wz_q   <= M1_PC[ADDR_W-1:0];
          end
          default: begin
            push_q  <= 1'b1;
            addr_q  <= {i_reg, ack_vec[7:0]};
            state_q <= SQ_REQ;
          end
        endcase
      end
    end
  end

  assign accept       = acc_q;
  assign nmi_taken    = nmi_q;
  assign push_pc      = push_q;
  assign pc_load      = load_q;
  assign new_pc       = pc_q;
  assign leave_halt   = halt_q;
  assign tbl_rd_valid = (state_q == SQ_REQ);
  assign tbl_rd_addr  = addr_q;
  assign wz           = wz_q;

  assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_rd_valid && !tbl_rd_ready) |=> (tbl_rd_valid && $stable(tbl_rd_addr)));

  assert_busy_no_take_R13: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!take_int && !take_nmi));

  assert_pulse_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !take_int && !take_nmi) |=> !accept);
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit #(
  parameter int          ADDR_W = 16,
  parameter logic [15:0] NMI_PC = 16'h0066,
  parameter logic [15:0] M1_PC  = 16'h0038
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retire,
  input  logic              retire_ei,
  input  logic              retire_di,
  input  logic              im_wr,
  input  logic [1:0]        im_val,
  input  logic              nmi_req,
  input  logic              int_req,
  input  logic              int_pend,
  input  logic [ADDR_W-9:0] i_reg,
  input  logic [ADDR_W+7:0] ack_vec,
  input  logic              tbl_rd_ready,
  input  logic              tbl_rsp_valid,
  input  logic [ADDR_W-1:0] tbl_rsp_data,
  output logic              accept,
  output logic              nmi_taken,
  output logic              push_pc,
  output logic              pc_load,
  output logic [ADDR_W-1:0] new_pc,
  output logic              leave_halt,
  output logic              ei_done,
  output logic              iff1,
  output logic              iff2,
  output logic              tbl_rd_valid,
  output logic [ADDR_W-1:0] tbl_rd_addr,
  output logic [ADDR_W-1:0] wz
);
  logic check, iff1_eff, busy, take_nmi, take_int;

  irq_enable_ctl u_en (
    .clk      (clk),
    .rst_n    (rst_n),
    .ret      (retire),
    .ret_ei   (retire_ei),
    .ret_di   (retire_di),
    .busy     (busy),
    .take_nmi (take_nmi),
    .take_int (take_int),
    .check    (check),
    .iff1_eff (iff1_eff),
    .iff1     (iff1),
    .iff2     (iff2),
    .ei_done  (ei_done)
  );

  irq_dispatch #(.ADDR_W(ADDR_W), .NMI_PC(NMI_PC), .M1_PC(M1_PC)) u_disp (
    .clk          (clk),
    .rst_n        (rst_n),
    .check        (check),
    .iff1_eff     (iff1_eff),
    .nmi_req      (nmi_req),
    .int_req      (int_req),
    .int_pend     (int_pend),
    .im_wr        (im_wr),
    .im_val       (im_val),
    .i_reg        (i_reg),
    .ack_vec      (ack_vec),
    .tbl_rd_ready (tbl_rd_ready),
    .tbl_rsp_valid(tbl_rsp_valid),
    .tbl_rsp_data (tbl_rsp_data),
    .take_nmi     (take_nmi),
    .take_int     (take_int),
    .busy         (busy),
    .accept       (accept),
    .nmi_taken    (nmi_taken),
    .push_pc      (push_pc),
    .pc_load      (pc_load),
    .new_pc       (new_pc),
    .leave_halt   (leave_halt),
    .tbl_rd_valid (tbl_rd_valid),
    .tbl_rd_addr  (tbl_rd_addr),
    .wz           (wz)
  );
endmodule

// File: tb/irq_accept_unit_test.sv
module irq_accept_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        retire = 0, retire_ei = 0, retire_di = 0, im_wr = 0;
  logic [1:0]  im_val = 0;
  logic        nmi_req = 0, int_req = 0, int_pend = 1;
  logic [7:0]  i_reg = 0;
  logic [23:0] ack_vec = 0;
  logic        tbl_rd_ready = 0, tbl_rsp_valid = 0;
  logic [15:0] tbl_rsp_data = 0;
  logic        accept, nmi_taken, push_pc, pc_load, leave_halt, ei_done, iff1, iff2, tbl_rd_valid;
  logic [15:0] new_pc, tbl_rd_addr, wz;

  int checks = 0;
  int fails  = 0;
  logic s_acc, s_nmi, s_push, s_load, s_halt, s_eid, s_i1, s_i2;
  logic [15:0] s_pc, s_wz;

  always #5 clk = ~clk;

  irq_accept_unit uut (
    .clk(clk), .rst_n(rst_n), .retire(retire), .retire_ei(retire_ei), .retire_di(retire_di),
    .im_wr(im_wr), .im_val(im_val), .nmi_req(nmi_req), .int_req(int_req), .int_pend(int_pend),
    .i_reg(i_reg), .ack_vec(ack_vec), .tbl_rd_ready(tbl_rd_ready), .tbl_rsp_valid(tbl_rsp_valid),
    .tbl_rsp_data(tbl_rsp_data), .accept(accept), .nmi_taken(nmi_taken), .push_pc(push_pc),
    .pc_load(pc_load), .new_pc(new_pc), .leave_halt(leave_halt), .ei_done(ei_done), .iff1(iff1),
    .iff2(iff2), .tbl_rd_valid(tbl_rd_valid), .tbl_rd_addr(tbl_rd_addr), .wz(wz)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic snap();
    s_acc = accept; s_nmi = nmi_taken; s_push = push_pc; s_load = pc_load; s_halt = leave_halt;
    s_eid = ei_done; s_i1 = iff1; s_i2 = iff2; s_pc = new_pc; s_wz = wz;
  endtask

  task automatic step(input logic ei, input logic di, input logic [23:0] vec);
    @(negedge clk);
    retire = 1; retire_ei = ei; retire_di = di; ack_vec = vec;
    @(negedge clk);
    snap();
    retire = 0; retire_ei = 0; retire_di = 0;
  endtask

  task automatic raise_int();
    @(negedge clk); int_req = 1;
    @(negedge clk); int_req = 0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk); im_wr = 1; im_val = m;
    @(negedge clk); im_wr = 0;
  endtask

  task automatic t_reset();
    chk("R10 iff1", iff1, 0); chk("R10 iff2", iff2, 0); chk("R10 accept", accept, 0);
    chk("R10 rd_valid", tbl_rd_valid, 0); chk("R10 wz", wz, 0); chk("R10 new_pc", new_pc, 0);
    chk("R10 ei_done", ei_done, 0);
    raise_int();
    step(1, 0, 0);
    step(0, 0, 24'h0100C3);
    chk("R10 mode0 after reset push", s_push, 0);
    chk("R10 mode0 after reset load", s_load, 1);
    chk("R10 mode0 after reset pc", s_pc, 16'h0100);
  endtask

  task automatic t_mode1();
    set_mode(2'd1);
    raise_int();
    step(1, 0, 0);
    chk("R6 no take on EI boundary", s_acc, 0);
    chk("R6 EI sets iff1", s_i1, 1);
    chk("R6 EI sets iff2", s_i2, 1);
    step(0, 0, 0);
    chk("R3 accept", s_acc, 1); chk("R3 push", s_push, 1); chk("R3 load", s_load, 1);
    chk("R3 pc", s_pc, 16'h0038);
    chk("R11 leave_halt", s_halt, 1);
    chk("R7 ei_done after EI+plain", s_eid, 1);
    chk("R2 iff1 cleared", s_i1, 0); chk("R2 iff2 cleared", s_i2, 0);
    chk("R12 wz", s_wz, 16'h0038);
    step(1, 0, 0);
    step(0, 0, 0);
    chk("R2 latch cleared on accept", s_acc, 0);
  endtask

  task automatic t_masking();
    step(0, 1, 0);
    raise_int();
    step(0, 0, 0);
    chk("R2 no take while disabled", s_acc, 0);
    step(1, 0, 0);
    step(0, 0, 0);
    chk("R9 kept with pend=1", s_acc, 1);
    raise_int();
    int_pend = 0;
    step(0, 0, 0);
    int_pend = 1;
    step(1, 0, 0);
    step(0, 0, 0);
    chk("R9 dropped with pend=0", s_acc, 0);
  endtask

  task automatic t_ei_di();
    step(0, 1, 0);
    raise_int();
    step(1, 0, 0);
    step(0, 1, 0);
    chk("R8 DI boundary sees cleared", s_acc, 0);
    chk("R7 no ei_done for EI then DI", s_eid, 0);
    chk("R8 iff1 cleared", s_i1, 0); chk("R8 iff2 cleared", s_i2, 0);
    step(1, 0, 0);
    step(1, 0, 0);
    chk("R7 no ei_done for EI then EI", s_eid, 0);
    chk("R6 no take on second EI", s_acc, 0);
    step(0, 0, 0);
    chk("R7 ei_done", s_eid, 1);
    chk("R8 latch kept and taken", s_acc, 1);
  endtask

  task automatic t_nmi();
    logic [15:0] wz0;
    step(1, 0, 0);
    step(0, 0, 0);
    wz0 = s_wz;
    @(negedge clk); nmi_req = 1; int_req = 1;
    @(negedge clk); int_req = 0;
    step(0, 0, 0);
    nmi_req = 0;
    chk("R1 accept", s_acc, 1); chk("R1 nmi_taken", s_nmi, 1);
    chk("R1 push", s_push, 1); chk("R1 pc", s_pc, 16'h0066);
    chk("R1 iff1 cleared", s_i1, 0); chk("R1 iff2 kept", s_i2, 1);
    chk("R1 wz unchanged", s_wz, wz0);
    chk("R11 leave_halt on nmi", s_halt, 1);
    step(0, 0, 0);
    chk("R2 maskable waits for iff1", s_acc, 0);
    step(1, 0, 0);
    step(0, 0, 0);
    chk("R1 maskable after nmi", s_acc, 1); chk("R1 not nmi", s_nmi, 0);
  endtask

  task automatic m0_case(input logic [7:0] op, input logic [15:0] tgt, input logic ep,
                         input logic el, input logic [15:0] epc);
    logic [15:0] pc0;
    logic [15:0] wz0;
    pc0 = new_pc; wz0 = wz;
    step(1, 0, 0);
    raise_int();
    step(0, 0, {tgt, op});
    chk("R4 accept", s_acc, 1);
    chk("R4 push", s_push, ep);
    chk("R4 load", s_load, el);
    chk("R4 pc", s_pc, el ? epc : pc0);
    chk("R12 wz", s_wz, el ? epc : wz0);
  endtask

  task automatic t_mode0();
    set_mode(2'd0);
    m0_case(8'h00, 16'h4444, 0, 0, 0);
    m0_case(8'hC3, 16'h1234, 0, 1, 16'h1234);
    m0_case(8'hCD, 16'hBEEF, 1, 1, 16'hBEEF);
    for (int n = 0; n < 8; n++)
      m0_case(8'hC7 | 8'(n << 3), 16'h7777, 1, 1, 16'(n * 8));
  endtask

  task automatic t_mode2();
    set_mode(2'd2);
    i_reg = 8'h40;
    step(1, 0, 0);
    raise_int();
    step(0, 0, 24'h00007A);
    chk("R5 accept", s_acc, 1); chk("R5 push", s_push, 1); chk("R5 no load yet", s_load, 0);
    chk("R5 rd_valid", tbl_rd_valid, 1); chk("R5 rd_addr", tbl_rd_addr, 16'h407A);
    @(negedge clk);
    chk("R5 valid held", tbl_rd_valid, 1); chk("R5 addr held", tbl_rd_addr, 16'h407A);
    step(1, 0, 0);
    chk("R13 EI ignored while busy", s_i1, 0);
    chk("R13 no accept while busy", s_acc, 0);
    @(negedge clk); tbl_rd_ready = 1;
    @(negedge clk); tbl_rd_ready = 0;
    chk("R5 valid drops after ready", tbl_rd_valid, 0);
    tbl_rsp_valid = 1; tbl_rsp_data = 16'h5566;
    @(negedge clk); tbl_rsp_valid = 0;
    chk("R5 load", pc_load, 1); chk("R5 pc", new_pc, 16'h5566);
    chk("R12 wz mode2", wz, 16'h5566);
    step(0, 0, 0);
    chk("R13 shadow untouched while busy", s_eid, 0);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_mode1();
    t_masking();
    t_ei_di();
    t_nmi();
    t_mode0();
    t_mode2();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule